// File: doc/BRIEF.md
# Fully Associative LRU Translation Buffer

This block caches virtual-to-physical page translations in a small, fully associative array. Each slot holds a page's virtual start, a page-size code, a physical base and three attribute flags: user, writable and global. A lookup compares the request address against the address range of every valid slot. One cycle later it returns hit or miss, the translated physical address and the user and writable flags of the slot that matched.

Refills come from an external page walker through a single-cycle insert port. An insert goes to the lowest-indexed free slot. When every slot is in use, it replaces the least recently used one. Software maintenance is a 2-bit command input with four codes: 0 idle, 1 flush everything, 2 flush every entry that is not global, 3 demap the entry that covers a given address. Recency is kept as a permutation of per-slot age counters, where age 0 is the most recently used slot.

Top module: `xlat_cache`

## Requirements
- R1: After reset no slot is valid, `lk_valid_o` is low, and any lookup misses.
- R2: A slot hits when its start is less than or equal to the lookup address and the lookup address is below start plus page size. The page-size code is 0 for 4 KiB, 1 for 2 MiB and 2 for 4 MiB.
- R3: On a hit, `lk_paddr_o` equals the slot's physical base ORed with the lookup address masked by (size - 1), and the slot's user and writable flags are returned. On a miss the address and both flags are zero.
- R4: A lookup result appears on the outputs in the cycle after `lk_req_i`, with `lk_valid_o` high for exactly that cycle.
- R5: An insert stores as the virtual start the insert address with its low bits below the page size cleared.
- R6: An insert with a free slot present evicts no valid entry. It takes the lowest-indexed free slot.
- R7: An insert with every slot valid overwrites the least recently used slot. The inserted entry becomes the most recently used.
- R8: A hitting lookup with `lk_touch_i` high makes that slot the most recently used. With `lk_touch_i` low the recency order does not change.
- R9: Command 1 (flush all) frees every slot.
- R10: Command 2 frees every slot whose global flag is clear and keeps global slots.
- R11: Command 3 frees the slot covering `mnt_vaddr_i`, if there is one, and leaves the recency order unchanged.
- R12: A non-zero command in the same cycle as a lookup is carried out, and that lookup reports a miss. An insert in the same cycle as a command is dropped.
- R13: A lookup in the same cycle as an insert sees the contents from before the insert. That lookup's recency update is suppressed in favour of the insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_req_i | input | 1 | Lookup request |
| lk_vaddr_i | input | VA_W | Lookup virtual address |
| lk_touch_i | input | 1 | Update recency on a lookup hit |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_paddr_o | output | PA_W | Translated physical address |
| lk_user_o | output | 1 | User flag of the hit slot |
| lk_wr_o | output | 1 | Writable flag of the hit slot |
| ins_i | input | 1 | Insert strobe |
| ins_vaddr_i | input | VA_W | Insert virtual address |
| ins_size_i | input | 2 | Page-size code |
| ins_pbase_i | input | PA_W | Physical page base |
| ins_user_i | input | 1 | User flag |
| ins_wr_i | input | 1 | Writable flag |
| ins_glob_i | input | 1 | Global flag |
| mnt_op_i | input | 2 | Maintenance command |
| mnt_vaddr_i | input | VA_W | Demap address |

## Verification
Maintenance and lookup can fall in the same cycle, and so can insert and lookup. The bench drives these pairs together in one cycle: a touching lookup alongside a non-global flush plus a competing insert, and a lookup of a page that is being inserted in that same cycle. A reference model judges the outcome. It applies the precedence of commands over inserts, and of inserts over lookups, to its own slot array and recency list. It then probes every known page to confirm which entries survived.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    MNT_NONE        = 2'd0,
    MNT_FLUSH_ALL   = 2'd1,
    MNT_FLUSH_LOCAL = 2'd2,
    MNT_DEMAP       = 2'd3
  } mnt_e;

  // size-1 mask per page-size code; code 3 behaves as 4 KiB
  function automatic logic [63:0] pg_mask(input logic [1:0] code);
    case (code)
      2'd1:    pg_mask = 64'h1F_FFFF;
      2'd2:    pg_mask = 64'h3F_FFFF;
      default: pg_mask = 64'hFFF;
    endcase
  endfunction
endpackage

// File: rtl/xlat_match.sv
module xlat_match import xlat_pkg::*; #(
  parameter int N    = 8,
  parameter int VA_W = 32,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]           valid_i,
  input  logic [N-1:0][VA_W-1:0] start_i,
  input  logic [N-1:0][1:0]      szc_i,
  input  logic [VA_W-1:0]        va_i,
  output logic                   hit_o,
  output logic [IW-1:0]          idx_o
);
  logic [N-1:0] m;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [63:0]   mk;
    logic [VA_W:0] lo, hi;
    assign mk   = pg_mask(szc_i[g]);
    assign lo   = {1'b0, start_i[g]};
    assign hi   = lo + {1'b0, mk[VA_W-1:0]} + 1'b1;
    assign m[g] = valid_i[g] && ({1'b0, va_i} >= lo) && ({1'b0, va_i} < hi);
  end

  always_comb begin
    hit_o = |m;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) if (m[k]) idx_o = IW'(k);
  end
endmodule

// File: rtl/xlat_age.sv
module xlat_age #(
  parameter int N   = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 touch_i,
  input  logic [IW-1:0]        touch_idx_i,
  output logic [N-1:0][IW-1:0] age_o
);
  logic [N-1:0][IW-1:0] age_q;
  logic [IW-1:0]        ref_age;

  assign ref_age = age_q[touch_idx_i];
  assign age_o   = age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N; k++) age_q[k] <= IW'(k);
    end else if (touch_i) begin
      for (int k = 0; k < N; k++) begin
        if (IW'(k) == touch_idx_i)   age_q[k] <= '0;
        else if (age_q[k] < ref_age) age_q[k] <= age_q[k] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N   = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         valid_i,
  input  logic [N-1:0][IW-1:0] age_i,
  output logic [IW-1:0]        idx_o
);
  logic [IW-1:0] free_idx, lru_idx;

  always_comb begin
    free_idx = '0;
    lru_idx  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (!valid_i[k])               free_idx = IW'(k);
      if (age_i[k] == IW'(N - 1))    lru_idx  = IW'(k);
    end
    idx_o = (&valid_i) ? lru_idx : free_idx;
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache import xlat_pkg::*; #(
  parameter int N    = 8,
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lk_req_i,
  input  logic [VA_W-1:0] lk_vaddr_i,
  input  logic            lk_touch_i,
  output logic            lk_valid_o,
  output logic            lk_hit_o,
  output logic [PA_W-1:0] lk_paddr_o,
  output logic            lk_user_o,
  output logic            lk_wr_o,
  input  logic            ins_i,
  input  logic [VA_W-1:0] ins_vaddr_i,
  input  logic [1:0]      ins_size_i,
  input  logic [PA_W-1:0] ins_pbase_i,
  input  logic            ins_user_i,
  input  logic            ins_wr_i,
  input  logic            ins_glob_i,
  input  logic [1:0]      mnt_op_i,
  input  logic [VA_W-1:0] mnt_vaddr_i
);
  logic [N-1:0]            valid_q, glob_q, user_q, wr_q;
  logic [N-1:0][VA_W-1:0]  start_q;
  logic [N-1:0][1:0]       szc_q;
  logic [N-1:0][PA_W-1:0]  pbase_q;
  logic [N-1:0][IW-1:0]    age_q;

  logic            mnt_act, ins_go, lk_go, touch;
  logic            lk_hit_c, dm_hit;
  logic [IW-1:0]   lk_idx, dm_idx, vic_idx, touch_idx;
  logic [63:0]     ins_mk, lk_mk;
  logic [VA_W-1:0] ins_start;
  logic [PA_W-1:0] paddr_c;

  assign mnt_act = (mnt_op_i != MNT_NONE);
  assign ins_go  = ins_i && !mnt_act;
  assign lk_go   = lk_req_i && lk_hit_c && !mnt_act;

  xlat_match #(.N(N), .VA_W(VA_W)) u_lk_match (
    .valid_i(valid_q), .start_i(start_q), .szc_i(szc_q),
    .va_i(lk_vaddr_i), .hit_o(lk_hit_c), .idx_o(lk_idx)
  );

  xlat_match #(.N(N), .VA_W(VA_W)) u_dm_match (
    .valid_i(valid_q), .start_i(start_q), .szc_i(szc_q),
    .va_i(mnt_vaddr_i), .hit_o(dm_hit), .idx_o(dm_idx)
  );

  xlat_victim #(.N(N)) u_victim (
    .valid_i(valid_q), .age_i(age_q), .idx_o(vic_idx)
  );

  // insert owns the recency port over a same-cycle lookup
  assign touch     = ins_go || (lk_go && lk_touch_i);
  assign touch_idx = ins_go ? vic_idx : lk_idx;

  xlat_age #(.N(N)) u_age (
    .clk_i(clk_i), .rst_ni(rst_ni), .touch_i(touch),
    .touch_idx_i(touch_idx), .age_o(age_q)
  );

  assign ins_mk    = pg_mask(ins_size_i);
  assign ins_start = ins_vaddr_i & ~ins_mk[VA_W-1:0];
  assign lk_mk     = pg_mask(szc_q[lk_idx]);
  assign paddr_c   = pbase_q[lk_idx] | PA_W'(lk_vaddr_i & lk_mk[VA_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      glob_q  <= '0;
      user_q  <= '0;
      wr_q    <= '0;
      start_q <= '0;
      szc_q   <= '0;
      pbase_q <= '0;
    end else begin
      case (mnt_op_i)
        MNT_FLUSH_ALL:   valid_q <= '0;
        MNT_FLUSH_LOCAL: valid_q <= valid_q & glob_q;
        MNT_DEMAP:       if (dm_hit) valid_q[dm_idx] <= 1'b0;
        default: begin
          if (ins_go) begin
            valid_q[vic_idx] <= 1'b1;
            glob_q[vic_idx]  <= ins_glob_i;
            user_q[vic_idx]  <= ins_user_i;
            wr_q[vic_idx]    <= ins_wr_i;
            start_q[vic_idx] <= ins_start;
            szc_q[vic_idx]   <= ins_size_i;
            pbase_q[vic_idx] <= ins_pbase_i;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_o <= 1'b0;
      lk_hit_o   <= 1'b0;
      lk_paddr_o <= '0;
      lk_user_o  <= 1'b0;
      lk_wr_o    <= 1'b0;
    end else begin
      lk_valid_o <= lk_req_i;
      lk_hit_o   <= lk_go;
      lk_paddr_o <= lk_go ? paddr_c : '0;
      lk_user_o  <= lk_go && user_q[lk_idx];
      lk_wr_o    <= lk_go && wr_q[lk_idx];
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int N    = 8,
  parameter int PA_W = 32,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 lk_req_i,
  input logic                 lk_touch_i,
  input logic                 ins_i,
  input logic [1:0]           mnt_op_i,
  input logic                 lk_valid_o,
  input logic                 lk_hit_o,
  input logic [PA_W-1:0]      lk_paddr_o,
  input logic [N-1:0]         valid_q,
  input logic [N-1:0]         glob_q,
  input logic [N-1:0][IW-1:0] age_q
);
  AST_RESULT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> lk_valid_o); // R4
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |=> !lk_valid_o); // R4
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_valid_o); // R4
  AST_MISS_ZERO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_o && !lk_hit_o) |-> (lk_paddr_o == '0)); // R3
  AST_MNT_FORCES_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_req_i && mnt_op_i != 2'd0) |=> !lk_hit_o); // R12
  AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mnt_op_i == 2'd1) |=> (valid_q == '0)); // R9
  AST_FLUSH_LOCAL_KEEPS_GLOBAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mnt_op_i == 2'd2) |=> ((valid_q & ~glob_q) == '0)); // R10
  AST_FREE_SLOT_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_i && mnt_op_i == 2'd0 && !(&valid_q))
      |=> ($countones(valid_q) == $countones($past(valid_q)) + 1)); // R6
  AST_NO_TOUCH_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ins_i && !(lk_req_i && lk_touch_i)) |=> $stable(age_q)); // R8
  AST_DEMAP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mnt_op_i == 2'd3) |=> $stable(age_q)); // R11

  for (genvar i = 0; i < N; i++) begin : g_i
    for (genvar j = i + 1; j < N; j++) begin : g_j
      AST_AGE_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        age_q[i] != age_q[j]); // R7
    end
  end
endmodule

bind xlat_cache xlat_cache_chk #(.N(N), .PA_W(PA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_req_i(lk_req_i), .lk_touch_i(lk_touch_i),
  .ins_i(ins_i), .mnt_op_i(mnt_op_i), .lk_valid_o(lk_valid_o), .lk_hit_o(lk_hit_o),
  .lk_paddr_o(lk_paddr_o), .valid_q(valid_q), .glob_q(glob_q), .age_q(age_q)
);

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
  localparam int N = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        lk_req = 0, lk_touch = 0, ins = 0, ins_user = 0, ins_wr = 0, ins_glob = 0;
  logic [31:0] lk_vaddr = 0, ins_vaddr = 0, ins_pbase = 0, mnt_vaddr = 0;
  logic [1:0]  ins_size = 0, mnt_op = 0;
  logic        lk_valid, lk_hit, lk_user, lk_wr;
  logic [31:0] lk_paddr;

  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  xlat_cache #(.N(N), .VA_W(32), .PA_W(32)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_req_i(lk_req), .lk_vaddr_i(lk_vaddr), .lk_touch_i(lk_touch),
    .lk_valid_o(lk_valid), .lk_hit_o(lk_hit), .lk_paddr_o(lk_paddr),
    .lk_user_o(lk_user), .lk_wr_o(lk_wr),
    .ins_i(ins), .ins_vaddr_i(ins_vaddr), .ins_size_i(ins_size), .ins_pbase_i(ins_pbase),
    .ins_user_i(ins_user), .ins_wr_i(ins_wr), .ins_glob_i(ins_glob),
    .mnt_op_i(mnt_op), .mnt_vaddr_i(mnt_vaddr)
  );

  // reference model
  bit          mv[N], mu[N], mw[N], mg[N];
  logic [31:0] ms[N], mp[N];
  logic [1:0]  mz[N];
  int          rec[$];

  int          q_due[$];
  logic [34:0] q_exp[$];
  string       q_tag[$];

  function automatic longint pg_bytes(logic [1:0] c);
    case (c)
      2'd1: return 64'd2097152;
      2'd2: return 64'd4194304;
      default: return 64'd4096;
    endcase
  endfunction

  function automatic int m_find(logic [31:0] va);
    for (int k = 0; k < N; k++)
      if (mv[k] && longint'(va) >= longint'(ms[k]) &&
          longint'(va) < longint'(ms[k]) + pg_bytes(mz[k])) return k;
    return -1;
  endfunction

  function automatic void m_touch(int k);
    for (int i = 0; i < rec.size(); i++) if (rec[i] == k) begin rec.delete(i); break; end
    rec.push_front(k);
  endfunction

  function automatic int m_victim();
    for (int k = 0; k < N; k++) if (!mv[k]) return k;
    return rec[rec.size()-1];
  endfunction

  task automatic op(input bit req, input logic [31:0] va, input bit tch,
                    input bit in, input logic [31:0] iva, input logic [1:0] isz,
                    input logic [31:0] ipb, input bit iu, input bit iw, input bit ig,
                    input logic [1:0] mop, input logic [31:0] mva, input string tag);
    int k;
    @(negedge clk);
    lk_req = req; lk_vaddr = va; lk_touch = tch;
    ins = in; ins_vaddr = iva; ins_size = isz; ins_pbase = ipb;
    ins_user = iu; ins_wr = iw; ins_glob = ig;
    mnt_op = mop; mnt_vaddr = mva;
    k = m_find(va);
    if (req) begin
      bit h;
      logic [31:0] pa;
      h  = (k >= 0) && (mop == 2'd0);
      pa = h ? (mp[k] | (va & 32'(pg_bytes(mz[k]) - 1))) : 32'h0;
      q_due.push_back(cyc + 1);
      q_exp.push_back({h, h && mu[k], h && mw[k], pa});
      q_tag.push_back(tag);
    end
    if (mop == 2'd1) begin
      for (int j = 0; j < N; j++) mv[j] = 0;
    end else if (mop == 2'd2) begin
      for (int j = 0; j < N; j++) mv[j] = mv[j] && mg[j];
    end else if (mop == 2'd3) begin
      int d;
      d = m_find(mva);
      if (d >= 0) mv[d] = 0;
    end else if (in) begin
      int v;
      v = m_victim();
      mv[v] = 1; mu[v] = iu; mw[v] = iw; mg[v] = ig; mz[v] = isz; mp[v] = ipb;
      ms[v] = iva & ~32'(pg_bytes(isz) - 1);
      m_touch(v);
    end else if (req && tch && k >= 0) begin
      m_touch(k);
    end
    @(posedge clk);
    #1;
    lk_req = 0; ins = 0; mnt_op = 0; lk_touch = 0;
  endtask

  task automatic lookup(input logic [31:0] va, input bit tch, input string tag);
    op(1, va, tch, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic insert(input logic [31:0] va, input logic [1:0] sz, input logic [31:0] pb,
                        input bit u, input bit w, input bit g, input string tag);
    op(0, 0, 0, 1, va, sz, pb, u, w, g, 0, 0, tag);
  endtask

  task automatic maint(input logic [1:0] mop, input logic [31:0] va, input string tag);
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, mop, va, tag);
  endtask

  logic [31:0] pages[12] = '{32'h0000_1008, 32'h0040_0100, 32'h00C0_0200, 32'h0000_3010,
                             32'h0001_0004, 32'h0001_1004, 32'h0001_2004, 32'h0001_3004,
                             32'h0002_0040, 32'h0002_1040, 32'h0003_0080, 32'h0005_0080};

  task automatic probe_all(input string tag);
    for (int i = 0; i < 12; i++) lookup(pages[i], 0, tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        logic [34:0] e;
        string t;
        void'(q_due.pop_front());
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        checks++;
        if (!lk_valid || {lk_hit, lk_user, lk_wr, lk_paddr} != e) begin
          fails++;
          $display("FAIL %s: valid=%0b got=%h expected=%h", t, lk_valid,
                   {lk_hit, lk_user, lk_wr, lk_paddr}, e);
        end
      end else if (lk_valid) begin
        checks++; fails++;
        $display("FAIL R4: result valid with no request due, got=1 expected=0");
      end
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) rec.push_back(k);
    repeat (3) @(negedge clk);
    checks++;
    if (lk_valid !== 1'b0) begin
      fails++; $display("FAIL R1: lk_valid during reset got=%b expected=0", lk_valid);
    end
    rst_n = 1'b1;
    @(posedge clk); #1;

    lookup(32'h0000_1000, 1, "R1");
    insert(32'h0000_1234, 2'd0, 32'h8000_0000, 1, 0, 0, "R5");
    lookup(32'h0000_1000, 1, "R2");
    lookup(32'h0000_1FFF, 0, "R3");
    lookup(32'h0000_2000, 0, "R2");
    lookup(32'h0000_0FFF, 0, "R2");
    insert(32'h0045_6789, 2'd1, 32'h1000_0000, 0, 1, 1, "R5");
    lookup(32'h005F_FFFF, 0, "R3");
    lookup(32'h0060_0000, 0, "R2");
    insert(32'h00C1_2345, 2'd2, 32'h2000_0000, 1, 1, 1, "R5");
    lookup(32'h00FF_FFFF, 0, "R5");
    lookup(32'h00BF_FFFF, 0, "R2");

    // lookup and insert of the same page in one cycle
    op(1, 32'h0000_3000, 1, 1, 32'h0000_3000, 2'd0, 32'h9000_0000, 0, 1, 0, 0, 0, "R13");
    lookup(32'h0000_3010, 0, "R13");

    for (int k = 0; k < 4; k++)
      insert(32'h0001_0000 + 32'(k) * 32'h1000, 2'd0, 32'hA000_0000 + 32'(k) * 32'h1000,
             k[0], 1, 0, "R6");
    probe_all("R6");

    // recency: untouched read of the LRU page, then refill evicts it
    lookup(32'h0000_1000, 0, "R8");
    insert(32'h0002_0000, 2'd0, 32'hB000_0000, 1, 0, 0, "R7");
    probe_all("R8");
    // touched read saves the current LRU page from the next refill
    lookup(32'h0040_0000, 1, "R8");
    insert(32'h0002_1000, 2'd0, 32'hB000_1000, 0, 0, 0, "R7");
    probe_all("R7");

    maint(2'd3, 32'h0001_1abc, "R11");
    lookup(32'h0001_1000, 0, "R11");
    insert(32'h0005_0000, 2'd0, 32'hC000_0000, 1, 1, 0, "R6");
    probe_all("R6");

    // command, lookup and insert all in one cycle
    op(1, 32'h0040_0000, 1, 1, 32'h0003_0000, 2'd0, 32'hD000_0000, 1, 1, 1, 2'd2, 0, "R12");
    probe_all("R10");
    lookup(32'h0003_0080, 0, "R12");

    maint(2'd1, 0, "R9");
    probe_all("R9");
    insert(32'h0003_0000, 2'd0, 32'hD000_0000, 1, 1, 0, "R6");
    insert(32'h00C0_0000, 2'd2, 32'h2000_0000, 0, 0, 1, "R6");
    probe_all("R6");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule